// File: doc/BRIEF.md
# Plucked-String Synthesis Engine

This block produces plucked-string tones by recirculating samples through a delay line. The delay line holds 10-bit unsigned samples, and its depth can be set anywhere from 2 to 128. An averaging unit adds the two oldest samples and halves the sum. Two mode inputs are decoded on every clock edge, and the decoded mode decides three things: whether the line shifts, what is written into it, and what the registered output shows.

In typical use the line is first filled with noise samples in the fill mode. The block then runs in the recirculate mode. In that mode each average is both emitted and written back into the line, so the content slowly smooths toward a decaying tone, with one output sample per clock. The block can also be used in two other ways:
- Kept in the fill mode, it works as a delay line of programmable depth.
- In the blend mode, it emits the average while shifting in fresh input.

Top module: `pks_string_synth`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the mode controller returns to idle. One cycle later `ready` is 1 and `sample_out` is 0, and every delay-line stage is 0.
- R2: Idle mode is `{load,iter}` = 00. In idle the delay line is not shifted, `sample_out` holds its previous value, and `ready` is 1 after the edge.
- R3: Fill mode is `{load,iter}` = 10. `sample_out` takes the oldest stored sample as it was before the edge, and `sample_in` enters the line as the newest sample.
- R4: Recirculate mode is `{load,iter}` = 01. `sample_out` takes floor((oldest + second oldest) / 2), and that same value enters the line as the newest sample.
- R5: Blend mode is `{load,iter}` = 11. `sample_out` takes floor((oldest + second oldest) / 2), and `sample_in` enters the line. The average is not written back.
- R6: `ready` is registered. It is 0 in the cycle after any edge taken in fill, recirculate or blend mode.
- R7: The delay-line depth is 129 minus `bypass`. `bypass` = 127 gives depth 2 and `bypass` = 1 gives depth 128. A value of 0 is clamped to depth 128.
- R8: Samples are unsigned and the sum is formed at 11 bits, so the average never wraps (1023 and 1023 average to 1023).
- R9: Any mode may follow any other mode on the next edge. In recirculate mode a new output sample appears on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Mode select, upper bit |
| iter | input | 1 | Mode select, lower bit |
| bypass | input | 7 | Depth control, depth = 129 - bypass |
| sample_in | input | 10 | Unsigned input sample |
| sample_out | output | 10 | Registered output sample |
| ready | output | 1 | High after an idle-mode edge |

## Verification
A short fill of large values at depth 2, followed by recirculation, tells a correct 11-bit sum apart from a wrapping 10-bit one. Filling exactly as many samples as the depth, then recirculating, separates correct tap indexing from an off-by-one depth. Long random runs mix all four modes and occasionally change `bypass`. These runs expose a write-back source swapped between blend and recirculate, an idle that still shifts or changes the output, and a `ready` that lags or leads by a cycle. Bypass values of 0, 1 and 127 exercise the clamp and both depth extremes.

// File: rtl/pks_pkg.sv
// Shared types for the plucked-string synthesis engine.
// Assumes the mode code is {load, iter} as seen at a rising edge.
package pks_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_ITER = 2'b01,
        MODE_LOAD = 2'b10,
        MODE_SUM  = 2'b11
    } pks_mode_e;
endpackage

// File: rtl/pks_mode_ctrl.sv
// Mode controller: decodes the two mode inputs each cycle and keeps a
// registered record of the applied mode so ready can be driven from a flop.
// Assumes synchronous active-low reset; reset forces the idle mode.
module pks_mode_ctrl
    import pks_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      iter,
    output pks_mode_e mode,
    output logic      shift_en,
    output logic      wb_avg,
    output logic      ready
);
    pks_mode_e applied_q;

    // Decode the present mode and the datapath controls it implies.
    always_comb begin
        mode     = pks_mode_e'({load, iter});
        shift_en = (mode != MODE_IDLE);
        wb_avg   = (mode == MODE_ITER);
    end

    // Record the mode taken at this edge; reset returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) applied_q <= MODE_IDLE;
        else        applied_q <= mode;
    end

    assign ready = (applied_q == MODE_IDLE);
endmodule

// File: rtl/pks_avg.sv
// Add-and-halve unit: floor of the mean of two unsigned samples.
// Assumes unsigned operands; one guard bit keeps the sum from wrapping.
module pks_avg #(
    parameter int DATA_W = 10
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] mean
);
    localparam int SUM_W = DATA_W + 1;
    logic [SUM_W-1:0] sum;

    // Widen, add, then drop the least significant bit.
    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        mean = sum[SUM_W-1:1];
    end
endmodule

// File: rtl/pks_delay_line.sv
// Programmable-depth delay line. Stage 0 is the newest sample. The two
// oldest samples of the active depth are tapped through variable indices.
// Assumes depth = MAX_DEPTH + 1 - bypass; bypass 0 is clamped to MAX_DEPTH.
module pks_delay_line #(
    parameter int DATA_W    = 10,
    parameter int MAX_DEPTH = 128,
    parameter int BYP_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    input  logic [BYP_W-1:0]  bypass,
    output logic [DATA_W-1:0] tap_old,
    output logic [DATA_W-1:0] tap_next
);
    localparam int IDX_W = $clog2(MAX_DEPTH);

    logic [DATA_W-1:0] stage_q [MAX_DEPTH];
    logic [IDX_W:0]    old_idx;
    logic [IDX_W:0]    next_idx;

    // Index of the oldest sample (depth-1), with the clamp for bypass 0.
    always_comb begin
        if (bypass == '0) old_idx = (IDX_W+1)'(MAX_DEPTH - 1);
        else              old_idx = (IDX_W+1)'(MAX_DEPTH) - (IDX_W+1)'(bypass);
        next_idx = old_idx - 1'b1;
    end

    // Head stage takes the write-back data when the line shifts.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q[0] <= '0;
        else if (shift_en) stage_q[0] <= din;
    end

    // Remaining stages each take their predecessor.
    for (genvar s = 1; s < MAX_DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)        stage_q[s] <= '0;
            else if (shift_en) stage_q[s] <= stage_q[s-1];
        end
    end

    assign tap_old  = stage_q[old_idx[IDX_W-1:0]];
    assign tap_next = stage_q[next_idx[IDX_W-1:0]];
endmodule

// File: rtl/pks_string_synth.sv
// Top of the plucked-string synthesis engine. Joins the mode controller,
// delay line and averaging unit, picks the write-back source and registers
// the output. Assumes synchronous active-low reset and one rising-edge clock.
module pks_string_synth
    import pks_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int MAX_DEPTH = 128,
    parameter int BYP_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              iter,
    input  logic [BYP_W-1:0]  bypass,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] sample_out,
    output logic              ready
);
    pks_mode_e         mode;
    logic              shift_en;
    logic              wb_avg;
    logic [DATA_W-1:0] tap_old;
    logic [DATA_W-1:0] tap_next;
    logic [DATA_W-1:0] mean;
    logic [DATA_W-1:0] wb_data;

    pks_mode_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .iter     (iter),
        .mode     (mode),
        .shift_en (shift_en),
        .wb_avg   (wb_avg),
        .ready    (ready)
    );

    pks_avg #(.DATA_W(DATA_W)) u_avg (
        .a    (tap_old),
        .b    (tap_next),
        .mean (mean)
    );

    // Write-back source: the average when recirculating, else the input.
    always_comb wb_data = wb_avg ? mean : sample_in;

    pks_delay_line #(
        .DATA_W    (DATA_W),
        .MAX_DEPTH (MAX_DEPTH),
        .BYP_W     (BYP_W)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (wb_data),
        .bypass   (bypass),
        .tap_old  (tap_old),
        .tap_next (tap_next)
    );

    // Output register: oldest sample in fill, average in recirculate and
    // blend, hold in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
        end else begin
            case (mode)
                MODE_LOAD: sample_out <= tap_old;
                MODE_ITER,
                MODE_SUM:  sample_out <= mean;
                default:   sample_out <= sample_out;
            endcase
        end
    end
endmodule

// File: rtl/pks_string_synth_chk.sv
// Checker for the plucked-string synthesis engine, bound to the top.
// Assumes it sees the top's ports and its two delay-line taps.
module pks_string_synth_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              iter,
    input logic              ready,
    input logic [DATA_W-1:0] sample_out,
    input logic [DATA_W-1:0] tap_old,
    input logic [DATA_W-1:0] tap_next
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ready && sample_out == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !iter) |=> ($stable(sample_out) && ready));

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load || iter) |=> !ready);

    // R3
    fill_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !iter) |=> sample_out == $past(tap_old));

    // R8
    mean_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iter |=> sample_out ==
            DATA_W'(({1'b0, $past(tap_old)} + {1'b0, $past(tap_next)}) >> 1));
endmodule

bind pks_string_synth pks_string_synth_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .iter       (iter),
    .ready      (ready),
    .sample_out (sample_out),
    .tap_old    (tap_old),
    .tap_next   (tap_next)
);

// File: tb/pks_string_synth_test.sv
module pks_string_synth_test;
    localparam int DW = 10;
    localparam int MD = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          iter = 1'b0;
    logic [6:0]    bypass = 7'd1;
    logic [DW-1:0] sample_in = '0;
    logic [DW-1:0] sample_out;
    logic          ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [MD];
    logic [DW-1:0] exp_out = '0;
    logic          exp_rdy = 1'b1;

    pks_string_synth uut (
        .clk(clk), .rst_n(rst_n), .load(load), .iter(iter),
        .bypass(bypass), .sample_in(sample_in),
        .sample_out(sample_out), .ready(ready)
    );

    always #10 clk = ~clk;

    function automatic int depth_of(input logic [6:0] b);
        return (b == 0) ? 128 : 129 - int'(b);
    endfunction

    function automatic logic [DW-1:0] mean_of(input logic [DW-1:0] a, input logic [DW-1:0] b);
        int s;
        s = int'(a) + int'(b);
        return DW'(s / 2);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < MD; i++) model[i] = '0;
        exp_out = '0;
        exp_rdy = 1'b1;
    endtask

    // Apply one edge in the given mode (called at a falling edge).
    task automatic step(input logic l, input logic it, input logic [DW-1:0] din);
        int d;
        logic [DW-1:0] old_v, nxt_v, m, wb;
        load = l; iter = it; sample_in = din;
        @(posedge clk);
        d = depth_of(bypass);
        old_v = model[d-1];
        nxt_v = model[d-2];
        m = mean_of(old_v, nxt_v);
        wb = it && !l ? m : din;
        if (l && !it)      exp_out = old_v;
        else if (it)       exp_out = m;
        if (l || it) begin
            for (int i = MD-1; i > 0; i--) model[i] = model[i-1];
            model[0] = wb;
        end
        exp_rdy = !(l || it);
        @(negedge clk);
        check((l && !it) ? "R3 fill" : (it && !l) ? "R4 recirculate" :
              (l && it) ? "R5 blend" : "R2 idle", sample_out, exp_out);
        check("R6 ready", {{(DW-1){1'b0}}, ready}, {{(DW-1){1'b0}}, exp_rdy});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 17;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset out", sample_out, '0);
        check("R1 reset ready", {{(DW-1){1'b0}}, ready}, 10'd1);

        // R1: fresh line reads zero through fill at depth 128
        bypass = 7'd1;
        for (int i = 0; i < 130; i++) step(1'b1, 1'b0, DW'(i + 5));

        // R7 R8: depth 2, large values, recirculate without wrap
        bypass = 7'd127;
        step(1'b1, 1'b0, 10'd1023);
        step(1'b1, 1'b0, 10'd1023);
        step(1'b0, 1'b1, 10'd0);
        check("R8 no wrap", sample_out, 10'd1023);
        step(1'b1, 1'b0, 10'd1022);
        step(1'b1, 1'b0, 10'd1);
        step(1'b0, 1'b1, 10'd0);
        check("R8 floor", sample_out, 10'd511);

        // R9: steady recirculation at depth 5, one new sample per edge
        bypass = 7'd124;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(200 * i + 3));
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 10'd0);

        // R2: idle holds out and line
        repeat (4) step(1'b0, 1'b0, 10'd777);
        // R5: blend then any-to-any switches (R9)
        step(1'b1, 1'b1, 10'd900);
        step(1'b0, 1'b0, 10'd1);
        step(1'b0, 1'b1, 10'd2);
        step(1'b1, 1'b0, 10'd3);
        step(1'b1, 1'b1, 10'd4);

        // R7: bypass 0 clamps to depth 128
        bypass = 7'd0;
        for (int i = 0; i < 140; i++) step(1'b1, 1'b0, DW'($urandom));

        // Random mixed traffic
        for (int i = 0; i < 1500; i++) begin
            if (i % 200 == 0) bypass = 7'($urandom);
            step(1'($urandom), 1'($urandom), DW'($urandom));
        end

        // R1: reset mid-run clears line and output
        load = 1'b1; iter = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; load = 1'b0;
        model_reset();
        check("R1 re-reset out", sample_out, '0);
        check("R1 re-reset ready", {{(DW-1){1'b0}}, ready}, 10'd1);
        bypass = 7'd126;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 10'd50);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule